// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder and Decoder

This block sits between the serial bitstream of a UART and an infrared transceiver. On the transmit side it turns every zero bit into one short high pulse on the optical output. A one bit leaves the output low. On the receive side it turns each incoming light pulse back into a zero bit that lasts one full bit period on the recovered serial line. The recovered line idles high.

Two pulse-width modes exist. In the normal mode the pulse is 3/16 of a bit period, timed by the 16x baud tick that the UART already uses. In the low-power mode the pulse is three periods of a slow reference tick, whatever the baud rate. That tick is made from the UART clock by an 8-bit divisor. The same reference tick also qualifies received pulses: anything shorter than three reference periods is dropped as noise. The block is active only when both the UART enable and the infrared enable are set.

Top module: `sir_endec`

## Requirements
- R1: After reset, `sir_out` is 0 and `rx_bit` is 1.
- R2: In normal mode, a `tx_bit` of 0 sampled at a bit start (the first `baud_tick` after enabling, then every 16th tick) gives exactly one high pulse on `sir_out`. The pulse lasts 3 `baud_tick` periods (12 clock cycles when ticks come every 4 cycles), and its width does not depend on `lp_div`.
- R3: A `tx_bit` of 1 at a bit start gives no pulse: `sir_out` stays 0 for that whole bit, in either mode.
- R4: In low-power mode (`lp_mode` = 1) with `lp_div` = N > 0, a zero bit gives one pulse of exactly 3*N clock cycles, independent of the baud tick rate.
- R5: In low-power mode with `lp_div` = 0, no reference tick exists: the encoder emits no pulse and the decoder accepts no pulse.
- R6: While `uart_en` or `sir_en` is 0, `sir_out` is 0 and `rx_bit` is 1 one cycle later, whatever `tx_bit` and `sir_in` do. The bit phase restarts on re-enable.
- R7: In normal mode, every pulse on `sir_in` of at least 2 clock cycles drives `rx_bit` low. It stays low from shortly after the pulse edge until the 16th following `baud_tick`, which is 61 to 64 cycles at a 4-cycle tick.
- R8: In low-power mode with `lp_div` = N, a pulse shorter than 3*N cycles leaves `rx_bit` at 1. A pulse longer than 3*N + 1 cycles drives `rx_bit` low for 16 `baud_tick` periods.
- R9: The encoder samples `tx_bit` only at a bit start. A change of `tx_bit` in the middle of a bit has no effect on `sir_out` until the next bit start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the baud rate |
| uart_en | input | 1 | Main UART enable |
| sir_en | input | 1 | Infrared coding enable |
| lp_mode | input | 1 | 1 selects the low-power fixed pulse width |
| lp_div | input | 8 | Clock divisor for the low-power reference tick, 0 = no tick |
| tx_bit | input | 1 | Serial transmit bit from the UART |
| sir_in | input | 1 | Pulse input from the transceiver, active high, asynchronous |
| sir_out | output | 1 | Pulse output to the transceiver, active high |
| rx_bit | output | 1 | Recovered serial receive bit, idles high |

## Verification
The properties assume that `baud_tick` is a single-cycle strobe, and that `tx_bit`, `lp_mode` and `lp_div` are synchronous to `clk` and change only at bit boundaries while no pulse is in flight. The bench keeps to this. It generates the tick itself in fixed 4-cycle slots and counts windows of exactly 16 ticks per bit. It changes the mode and the divisor only between windows, after every pulse has ended. The `sir_in` line is treated as asynchronous, and it is driven only with pulses well clear of the qualification threshold. This keeps the count of synchronizer cycles from deciding any result.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int BIT_TICKS    = 16;
  localparam int PULSE_TICKS  = 3;
  localparam int LP_PERIODS   = 3;
  localparam int MAX_PULSE    = (PULSE_TICKS > LP_PERIODS) ? PULSE_TICKS : LP_PERIODS;
  localparam int PCNT_W       = $clog2(MAX_PULSE + 1);

  typedef enum logic [1:0] {
    QUAL_IDLE,
    QUAL_WAIT
  } qual_state_t;
endpackage

// File: rtl/sir_lp_divider.sv
module sir_lp_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == div - DIV_W'(1));
  assign tick   = (div != '0) && at_end;

  always_ff @(posedge clk) begin
    if (rst || restart || div == '0) begin
      cnt <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sir_encoder.sv
module sir_encoder
  import sir_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int BIT_TCKS  = BIT_TICKS,
  parameter int PULSE_TKS = PULSE_TICKS,
  parameter int LP_PERS   = LP_PERIODS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             baud_tick,
  input  logic             tx_bit,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             lp_tick,
  output logic             sir_out,
  output logic             lp_restart
);
  localparam int PHASE_W = $clog2(BIT_TCKS);

  logic [PHASE_W-1:0] phase;
  logic [PCNT_W-1:0]  pcnt;
  logic               pulse_lp;
  logic               bit_start;
  logic               start;
  logic               step;
  logic               last_step;

  assign bit_start  = active && baud_tick && (phase == '0);
  assign start      = bit_start && !tx_bit && (!lp_mode || lp_div != '0);
  assign lp_restart = start && lp_mode;
  assign step       = pulse_lp ? lp_tick : baud_tick;
  assign last_step  = pulse_lp ? (pcnt == PCNT_W'(LP_PERS - 1))
                               : (pcnt == PCNT_W'(PULSE_TKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase <= '0;
    end else if (baud_tick) begin
      phase <= (phase == PHASE_W'(BIT_TCKS - 1)) ? '0 : phase + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sir_out  <= 1'b0;
      pcnt     <= '0;
      pulse_lp <= 1'b0;
    end else if (start) begin
      sir_out  <= 1'b1;
      pcnt     <= '0;
      pulse_lp <= lp_mode;
    end else if (sir_out && step) begin
      if (last_step) begin
        sir_out <= 1'b0;
      end else begin
        pcnt <= pcnt + PCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sir_decoder.sv
module sir_decoder
  import sir_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BIT_TCKS    = BIT_TICKS,
  parameter int LP_PERS     = LP_PERIODS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             baud_tick,
  input  logic             sir_in,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             lp_tick,
  output logic             rx_bit,
  output logic             lp_restart
);
  localparam int HOLD_W = $clog2(BIT_TCKS);

  logic [SYNC_STAGES-1:0] sync;
  logic                   seen;
  logic                   prev;
  logic                   rise;
  qual_state_t            qstate;
  logic [PCNT_W-1:0]      qcnt;
  logic                   accept;
  logic [HOLD_W-1:0]      hold;

  assign seen = sync[SYNC_STAGES-1];
  assign rise = active && seen && !prev;
  assign lp_restart = rise && lp_mode && (lp_div != '0);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sync <= '0;
      prev <= 1'b0;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], sir_in};
      prev <= seen;
    end
  end

  always_comb begin
    accept = 1'b0;
    if (rise && !lp_mode) begin
      accept = 1'b1;
    end else if (qstate == QUAL_WAIT && seen && lp_tick &&
                 qcnt == PCNT_W'(LP_PERS - 1)) begin
      accept = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      qstate <= QUAL_IDLE;
      qcnt   <= '0;
    end else if (lp_restart) begin
      qstate <= QUAL_WAIT;
      qcnt   <= '0;
    end else if (qstate == QUAL_WAIT) begin
      if (!seen || accept || !lp_mode) begin
        qstate <= QUAL_IDLE;
      end else if (lp_tick) begin
        qcnt <= qcnt + PCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      rx_bit <= 1'b1;
      hold   <= '0;
    end else if (accept) begin
      rx_bit <= 1'b0;
      hold   <= '0;
    end else if (!rx_bit && baud_tick) begin
      if (hold == HOLD_W'(BIT_TCKS - 1)) begin
        rx_bit <= 1'b1;
      end else begin
        hold <= hold + HOLD_W'(1);
      end
    end
  end
endmodule

// File: rtl/sir_endec.sv
module sir_endec #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_tick,
  input  logic             uart_en,
  input  logic             sir_en,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             tx_bit,
  input  logic             sir_in,
  output logic             sir_out,
  output logic             rx_bit
);
  logic active;
  logic tx_restart, tx_lp_tick;
  logic rx_restart, rx_lp_tick;

  assign active = uart_en && sir_en;

  sir_lp_divider #(.DIV_W(DIV_W)) u_tx_div (
    .clk(clk), .rst(rst), .restart(tx_restart), .div(lp_div), .tick(tx_lp_tick)
  );

  sir_lp_divider #(.DIV_W(DIV_W)) u_rx_div (
    .clk(clk), .rst(rst), .restart(rx_restart), .div(lp_div), .tick(rx_lp_tick)
  );

  sir_encoder #(.DIV_W(DIV_W)) u_enc (
    .clk(clk), .rst(rst), .active(active), .baud_tick(baud_tick),
    .tx_bit(tx_bit), .lp_mode(lp_mode), .lp_div(lp_div),
    .lp_tick(tx_lp_tick), .sir_out(sir_out), .lp_restart(tx_restart)
  );

  sir_decoder #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst(rst), .active(active), .baud_tick(baud_tick),
    .sir_in(sir_in), .lp_mode(lp_mode), .lp_div(lp_div),
    .lp_tick(rx_lp_tick), .rx_bit(rx_bit), .lp_restart(rx_restart)
  );
endmodule

// File: rtl/sir_endec_checker.sv
module sir_endec_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             uart_en,
  input logic             sir_en,
  input logic             lp_mode,
  input logic [DIV_W-1:0] lp_div,
  input logic             tx_bit,
  input logic             sir_in,
  input logic             sir_out,
  input logic             rx_bit
);
  logic [1:0] since_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_hi <= 2'd3;
    end else if (sir_in) begin
      since_hi <= 2'd0;
    end else if (since_hi != 2'd3) begin
      since_hi <= since_hi + 2'd1;
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(uart_en && sir_en) |=> (!sir_out && rx_bit)); // R6

  AST_PULSE_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(sir_out) |-> !$past(tx_bit)); // R3

  AST_DIV_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    $rose(sir_out) |-> (!$past(lp_mode) || $past(lp_div) != '0)); // R5

  AST_RX_NEEDS_LIGHT: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_bit) |-> (since_hi <= 2'd2)); // R7
endmodule

bind sir_endec sir_endec_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sir_endec_bench.sv
module sir_endec_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       uart_en = 1'b1;
  logic       sir_en = 1'b1;
  logic       lp_mode = 1'b0;
  logic [7:0] lp_div = 8'd0;
  logic       tx_bit = 1'b1;
  logic       sir_in = 1'b0;
  logic       sir_out;
  logic       rx_bit;

  int total = 0;
  int bad = 0;
  int hi_cnt, rise_cnt, lo_cnt;
  logic prev_out;
  bit done = 1'b0;

  // {lp_mode, lp_div, tx_bit, expected high cycles}
  localparam logic [17:0] ENC_VEC [7] = '{
    {1'b0, 8'd0,  1'b0, 8'd12},
    {1'b0, 8'd0,  1'b1, 8'd0},
    {1'b1, 8'd3,  1'b0, 8'd9},
    {1'b1, 8'd10, 1'b0, 8'd30},
    {1'b1, 8'd3,  1'b1, 8'd0},
    {1'b1, 8'd0,  1'b0, 8'd0},
    {1'b0, 8'd5,  1'b0, 8'd12}
  };

  always #2 clk = ~clk;

  sir_endec u_sir_endec (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .uart_en(uart_en),
    .sir_en(sir_en), .lp_mode(lp_mode), .lp_div(lp_div), .tx_bit(tx_bit),
    .sir_in(sir_in), .sir_out(sir_out), .rx_bit(rx_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Run n slots of 4 cycles, tick in the first cycle of each slot.
  task automatic run_slots(input int n, input int p_start, input int p_len,
                           input logic tx_a, input int sw_idx, input logic tx_b);
    hi_cnt = 0; rise_cnt = 0; lo_cnt = 0;
    for (int idx = 0; idx < n * 4; idx++) begin
      @(negedge clk);
      if (sir_out) hi_cnt++;
      if (sir_out && !prev_out) rise_cnt++;
      if (!rx_bit) lo_cnt++;
      prev_out = sir_out;
      baud_tick = (idx % 4 == 0);
      sir_in = (idx >= p_start) && (idx < p_start + p_len);
      tx_bit = (idx < sw_idx) ? tx_a : tx_b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    prev_out = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sir_out after reset", int'(sir_out), 0);
    check("R1 rx_bit after reset", int'(rx_bit), 1);

    // Encoder vectors: one bit (16 ticks) each, bit phase kept aligned.
    for (int v = 0; v < 7; v++) begin
      lp_mode = ENC_VEC[v][17];
      lp_div  = ENC_VEC[v][16:9];
      run_slots(16, 9999, 0, ENC_VEC[v][8], 9999, ENC_VEC[v][8]);
      check($sformatf("R2/R3/R4/R5 vec%0d width", v), hi_cnt, int'(ENC_VEC[v][7:0]));
      check($sformatf("R2/R3/R4/R5 vec%0d pulses", v), rise_cnt,
            (ENC_VEC[v][7:0] != 0) ? 1 : 0);
    end

    // R9: tx_bit falls mid-bit, no pulse until next bit start.
    lp_mode = 1'b0; lp_div = 8'd0;
    run_slots(16, 9999, 0, 1'b1, 20, 1'b0);
    check("R9 mid-bit change ignored", hi_cnt, 0);
    run_slots(16, 9999, 0, 1'b0, 9999, 1'b0);
    check("R9 next bit start sampled", hi_cnt, 12);

    // R6: either enable low keeps outputs idle.
    sir_en = 1'b0;
    run_slots(24, 8, 12, 1'b0, 9999, 1'b0);
    check("R6 sir_en off tx", hi_cnt, 0);
    check("R6 sir_en off rx", lo_cnt, 0);
    sir_en = 1'b1; uart_en = 1'b0;
    run_slots(24, 8, 12, 1'b0, 9999, 1'b0);
    check("R6 uart_en off tx", hi_cnt, 0);
    check("R6 uart_en off rx", lo_cnt, 0);
    uart_en = 1'b1;
    run_slots(16, 9999, 0, 1'b0, 9999, 1'b0);
    check("R6 phase restarts on enable", hi_cnt, 12);

    // Decoder, normal mode.
    tx_bit = 1'b1;
    run_slots(24, 2, 12, 1'b1, 9999, 1'b1);
    check_range("R7 normal rx low length", lo_cnt, 61, 64);
    run_slots(24, 2, 2, 1'b1, 9999, 1'b1);
    check_range("R7 short pulse accepted", lo_cnt, 61, 64);

    // Decoder, low-power mode, divisor 3.
    lp_mode = 1'b1; lp_div = 8'd3;
    run_slots(24, 2, 6, 1'b1, 9999, 1'b1);
    check("R8 glitch rejected", lo_cnt, 0);
    run_slots(24, 2, 12, 1'b1, 9999, 1'b1);
    check_range("R8 long pulse accepted", lo_cnt, 61, 64);

    // Decoder, low-power mode, divisor 0.
    lp_div = 8'd0;
    run_slots(24, 2, 40, 1'b1, 9999, 1'b1);
    check("R5 divisor zero rx", lo_cnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule